// File: doc/BRIEF.md
# Two-Line Pin Event Interrupt Detector

This block watches a bank of already-synchronized input pins and turns pin activity into interrupt requests. Each pin has four independent detect enables: upward transition, downward transition, held high and held low. Any combination may be set on a pin. Every event that is detected is recorded in two status vectors, one for each interrupt line. Each status bit stays set until software clears it through that line's acknowledge register.

Each line has its own enable mask. Software changes a mask only through a set alias and a clear alias, in which only the 1 bits act. The line's output is a registered OR, across all pins, of that line's status ANDed with its mask. A simple register bus carries single-cycle writes. Reads are combinational from the address.

The bus register layout uses word-aligned byte offsets. 0x00 holds the rise enables, 0x04 the fall enables, 0x08 the high-level enables and 0x0C the low-level enables. 0x10 and 0x14 hold the raw status of line 0 and line 1. 0x18 and 0x1C hold the masked status and acknowledge of line 0 and line 1. 0x20 and 0x24 are the mask set aliases, and 0x28 and 0x2C are the mask clear aliases. Each alias reads back its line's mask.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset all detect enables, both masks and both status vectors read 0, and both interrupt outputs are low.
- R2: With a pin's rise enable set, a 0-to-1 change on that pin sets its bit in both lines' raw status at the next clock edge. A pin without that enable records nothing.
- R3: With a pin's fall enable set, a 1-to-0 change sets its status bit at the next edge. A 0-to-1 change on that pin records nothing unless its rise enable is also set.
- R4: A pin with both edge enables set records an event on either transition.
- R5: With the high-level enable set, the status bit is set again on every edge while the pin is high. An acknowledge during that time leaves the bit set. An acknowledge after the pin drops clears it.
- R6: With the low-level enable set, the status bit is set on every edge while the pin is low.
- R7: Raw status reads show recorded events whatever the mask holds. The masked status read of a line returns its raw status ANDed with that line's mask.
- R8: A write to a line's set alias ORs the written ones into its mask. A write to the clear alias clears the written ones. Zero bits leave the mask unchanged, and both aliases read back the mask.
- R9: Writing 1 to a bit of a line's acknowledge register clears that bit in that line only. Writing 0 changes nothing, and a status bit never clears without an acknowledge.
- R10: Each interrupt output equals, one clock later, the OR over all pins of that line's status ANDed with its mask.
- R11: When a new event and an acknowledge hit the same bit in one cycle, the bit ends set.
- R12: Writes to raw status offsets or to unmapped or misaligned addresses change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NPINS | Synchronized pin levels |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address for the read or the write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, combinational from bus_addr |
| irq | output | NLINES | Interrupt request, one per line |

## Verification
Read data follows the address in the same cycle, so the bench samples it shortly after it changes the address. A pin change or a register write takes effect at the next rising edge. It is therefore visible in the status and mask reads half a cycle later. An interrupt output moves one edge after the status or mask that causes it, which is two edges after the pin change. The bench drives inputs on falling edges and compares every output against its own model a quarter period after each rising edge. The directed checks read at the falling edge that follows the edge where each effect is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned DETECT_NUM = 4;   // rise, fall, high, low

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_DETECT,
    GRP_RAW,
    GRP_STAT,
    GRP_ENSET,
    GRP_ENCLR
  } reg_grp_e;

  typedef struct packed {
    reg_grp_e   grp;
    logic [3:0] idx;
  } reg_sel_t;

  // Word map: 4 detect words, then per-line groups raw, stat, set, clear.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned nlines);
    reg_sel_t    s;
    int unsigned w;
    s.grp = GRP_NONE;
    s.idx = '0;
    w     = 32'(a[ADDR_W-1:2]);
    if (a[1:0] == 2'b00) begin
      if (w < DETECT_NUM) begin
        s.grp = GRP_DETECT;
        s.idx = 4'(w);
      end else begin
        w = w - DETECT_NUM;
        if (w < nlines) begin
          s.grp = GRP_RAW;   s.idx = 4'(w);
        end else if (w < 2 * nlines) begin
          s.grp = GRP_STAT;  s.idx = 4'(w - nlines);
        end else if (w < 3 * nlines) begin
          s.grp = GRP_ENSET; s.idx = 4'(w - 2 * nlines);
        end else if (w < 4 * nlines) begin
          s.grp = GRP_ENCLR; s.idx = 4'(w - 3 * nlines);
        end
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NLINES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  reg_sel_t                           sel,
  input  logic [NPINS-1:0]                   wdata,
  output logic [DETECT_NUM-1:0][NPINS-1:0]   det_q,
  output logic [NLINES-1:0][NPINS-1:0]       en_q,
  output logic [NLINES-1:0][NPINS-1:0]       ack,
  output logic [NLINES-1:0]                  set_hit,
  output logic [NLINES-1:0]                  clr_hit
);

  function automatic logic [NPINS-1:0] mask_update(input logic [NPINS-1:0] cur,
                                                   input logic set_w,
                                                   input logic clr_w,
                                                   input logic [NPINS-1:0] d);
    logic [NPINS-1:0] up;
    up = set_w ? (cur | d) : cur;
    return clr_w ? (up & ~d) : up;
  endfunction

  for (genvar d = 0; d < DETECT_NUM; d++) begin : g_det
    logic hit;
    assign hit = we && (sel.grp == GRP_DETECT) && (sel.idx == 4'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   det_q[d] <= '0;
      else if (hit) det_q[d] <= wdata;
    end
  end

  for (genvar k = 0; k < NLINES; k++) begin : g_line
    assign set_hit[k] = we && (sel.grp == GRP_ENSET) && (sel.idx == 4'(k));
    assign clr_hit[k] = we && (sel.grp == GRP_ENCLR) && (sel.idx == 4'(k));
    assign ack[k]     = (we && (sel.grp == GRP_STAT) && (sel.idx == 4'(k)))
                        ? wdata : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[k] <= '0;
      else        en_q[k] <= mask_update(en_q[k], set_hit[k], clr_hit[k], wdata);
    end
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] rise_en,
  input  logic [NPINS-1:0] fall_en,
  input  logic [NPINS-1:0] high_en,
  input  logic [NPINS-1:0] low_en,
  output logic [NPINS-1:0] edge_ev,
  output logic [NPINS-1:0] level_ev,
  output logic [NPINS-1:0] ev
);

  logic [NPINS-1:0] pin_q;

  function automatic logic [NPINS-1:0] edges(input logic [NPINS-1:0] cur,
                                             input logic [NPINS-1:0] prev,
                                             input logic [NPINS-1:0] up_en,
                                             input logic [NPINS-1:0] dn_en);
    return ((cur & ~prev) & up_en) | ((prev & ~cur) & dn_en);
  endfunction

  function automatic logic [NPINS-1:0] levels(input logic [NPINS-1:0] cur,
                                              input logic [NPINS-1:0] hi_en,
                                              input logic [NPINS-1:0] lo_en);
    return (cur & hi_en) | (~cur & lo_en);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  assign edge_ev  = edges(pin_in, pin_q, rise_en, fall_en);
  assign level_ev = levels(pin_in, high_en, low_en);
  assign ev       = edge_ev | level_ev;

endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] ev,
  input  logic [NPINS-1:0] ack,
  input  logic [NPINS-1:0] en,
  output logic [NPINS-1:0] stat,
  output logic             irq
);

  // Event is applied after the acknowledge, so a colliding event survives.
  function automatic logic [NPINS-1:0] next_stat(input logic [NPINS-1:0] cur,
                                                 input logic [NPINS-1:0] clr,
                                                 input logic [NPINS-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic line_req(input logic [NPINS-1:0] s,
                                    input logic [NPINS-1:0] m);
    return |(s & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= next_stat(stat, ack, ev);
      irq  <= line_req(stat, en);
    end
  end

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NLINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic [NLINES-1:0] irq
);

  localparam int unsigned IDX_RISE = 0;
  localparam int unsigned IDX_FALL = 1;
  localparam int unsigned IDX_HIGH = 2;
  localparam int unsigned IDX_LOW  = 3;

  reg_sel_t                           sel;
  logic [DETECT_NUM-1:0][NPINS-1:0]   det_all;
  logic [NLINES-1:0][NPINS-1:0]       en_all;
  logic [NLINES-1:0][NPINS-1:0]       ack_all;
  logic [NLINES-1:0][NPINS-1:0]       stat_all;
  logic [NLINES-1:0]                  set_hit;
  logic [NLINES-1:0]                  clr_hit;
  logic [NPINS-1:0]                   edge_ev;
  logic [NPINS-1:0]                   level_ev;
  logic [NPINS-1:0]                   ev_all;

  assign sel = decode_addr(bus_addr, NLINES);

  gpio_irq_cfg #(.NPINS(NPINS), .NLINES(NLINES)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bus_we),
    .sel     (sel),
    .wdata   (bus_wdata),
    .det_q   (det_all),
    .en_q    (en_all),
    .ack     (ack_all),
    .set_hit (set_hit),
    .clr_hit (clr_hit)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .rise_en  (det_all[IDX_RISE]),
    .fall_en  (det_all[IDX_FALL]),
    .high_en  (det_all[IDX_HIGH]),
    .low_en   (det_all[IDX_LOW]),
    .edge_ev  (edge_ev),
    .level_ev (level_ev),
    .ev       (ev_all)
  );

  for (genvar k = 0; k < NLINES; k++) begin : g_ln
    gpio_irq_line #(.NPINS(NPINS)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_all),
      .ack   (ack_all[k]),
      .en    (en_all[k]),
      .stat  (stat_all[k]),
      .irq   (irq[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel.grp)
      GRP_DETECT: begin
        for (int d = 0; d < int'(DETECT_NUM); d++)
          if (sel.idx == 4'(d)) bus_rdata = det_all[d];
      end
      GRP_RAW: begin
        for (int k = 0; k < int'(NLINES); k++)
          if (sel.idx == 4'(k)) bus_rdata = stat_all[k];
      end
      GRP_STAT: begin
        for (int k = 0; k < int'(NLINES); k++)
          if (sel.idx == 4'(k)) bus_rdata = stat_all[k] & en_all[k];
      end
      GRP_ENSET, GRP_ENCLR: begin
        for (int k = 0; k < int'(NLINES); k++)
          if (sel.idx == 4'(k)) bus_rdata = en_all[k];
      end
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned NLINES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NLINES-1:0]            irq,
  input logic [NLINES-1:0][NPINS-1:0] stat,
  input logic [NLINES-1:0][NPINS-1:0] en,
  input logic [NLINES-1:0][NPINS-1:0] ack,
  input logic [NPINS-1:0]             ev,
  input logic [NLINES-1:0]            set_hit,
  input logic [NLINES-1:0]            clr_hit
);

  for (genvar k = 0; k < NLINES; k++) begin : g_chk
    // R10
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] == $past(|(stat[k] & en[k])));

    // R11
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev != '0) |=> ((stat[k] & $past(ev)) == $past(ev)));

    // R9
    clear_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[k] != '0) |=> (($past(stat[k]) & ~stat[k] & ~$past(ack[k])) == '0));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_hit[k] && !clr_hit[k]) |=> $stable(en[k]));
  end

endmodule

bind gpio_irq_top gpio_irq_chk #(.NPINS(NPINS), .NLINES(NLINES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .stat    (stat_all),
  .en      (en_all),
  .ack     (ack_all),
  .ev      (ev_all),
  .set_hit (set_hit),
  .clr_hit (clr_hit)
);

// File: tb/gpio_irq_top_bench.sv
module gpio_irq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 32;
  localparam int NLINES     = 2;
  localparam int RAND_CYC   = 4000;

  localparam logic [7:0] A_RISE = 8'h00, A_FALL = 8'h04, A_HIGH = 8'h08, A_LOW = 8'h0C;
  localparam logic [7:0] A_RAW0 = 8'h10, A_RAW1 = 8'h14, A_ST0 = 8'h18, A_ST1 = 8'h1C;
  localparam logic [7:0] A_SET0 = 8'h20, A_SET1 = 8'h24, A_CLR0 = 8'h28, A_CLR1 = 8'h2C;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NPINS-1:0]  pins;
  logic              we;
  logic [7:0]        addr;
  logic [NPINS-1:0]  wdata;
  logic [NPINS-1:0]  rdata;
  logic [NLINES-1:0] irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_top #(.NPINS(NPINS), .NLINES(NLINES)) u_gpio_irq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pins),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  // Reference model written from the requirements.
  logic [NPINS-1:0]  m_rise, m_fall, m_hi, m_lo, m_pq;
  logic [NPINS-1:0]  m_en [NLINES];
  logic [NPINS-1:0]  m_st [NLINES];
  logic [NLINES-1:0] m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rise <= '0; m_fall <= '0; m_hi <= '0; m_lo <= '0; m_pq <= '0; m_irq <= '0;
      for (int k = 0; k < NLINES; k++) begin m_en[k] <= '0; m_st[k] <= '0; end
    end else begin
      logic [NPINS-1:0] evt;
      evt = '0;
      for (int p = 0; p < NPINS; p++) begin
        if (m_rise[p] && pins[p] && !m_pq[p]) evt[p] = 1'b1;
        if (m_fall[p] && !pins[p] && m_pq[p]) evt[p] = 1'b1;
        if (m_hi[p] && pins[p])               evt[p] = 1'b1;
        if (m_lo[p] && !pins[p])              evt[p] = 1'b1;
      end
      for (int k = 0; k < NLINES; k++) begin
        logic [NPINS-1:0] clr;
        m_irq[k] <= ((m_st[k] & m_en[k]) != '0);
        clr = (we && addr == A_ST0 + 8'(4*k)) ? wdata : '0;
        m_st[k] <= evt | (m_st[k] & ~clr);
        if (we && addr == A_SET0 + 8'(4*k)) m_en[k] <= m_en[k] | wdata;
        if (we && addr == A_CLR0 + 8'(4*k)) m_en[k] <= m_en[k] & ~wdata;
      end
      if (we && addr == A_RISE) m_rise <= wdata;
      if (we && addr == A_FALL) m_fall <= wdata;
      if (we && addr == A_HIGH) m_hi   <= wdata;
      if (we && addr == A_LOW)  m_lo   <= wdata;
      m_pq <= pins;
    end
  end

  function automatic logic [NPINS-1:0] model_read(input logic [7:0] a);
    case (a)
      A_RISE: return m_rise;
      A_FALL: return m_fall;
      A_HIGH: return m_hi;
      A_LOW:  return m_lo;
      A_RAW0: return m_st[0];
      A_RAW1: return m_st[1];
      A_ST0:  return m_st[0] & m_en[0];
      A_ST1:  return m_st[1] & m_en[1];
      A_SET0, A_CLR0: return m_en[0];
      A_SET1, A_CLR1: return m_en[1];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Continuous comparison a quarter period after each rising edge.
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      check("R10 irq vs model", 32'(irq), 32'(m_irq));
      check("R7 rdata vs model", rdata, model_read(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 12; a++) rdchk("R1 reset read", 8'(4*a), 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    // R2 rising edge, R7 masked status with empty mask
    wr(A_RISE, 32'h1);
    pins[0] = 1'b1; tick();
    rdchk("R2 raw0 rise", A_RAW0, 32'h1);
    rdchk("R2 raw1 rise", A_RAW1, 32'h1);
    rdchk("R7 masked with empty mask", A_ST0, 32'h0);

    // R10 line follows mask one edge later
    wr(A_SET0, 32'h1);
    check("R10 irq not yet", 32'(irq), 32'h0);
    tick();
    check("R10 irq0 only", 32'(irq), 32'h1);
    rdchk("R7 masked status", A_ST0, 32'h1);

    // R9 acknowledge
    wr(A_ST0, 32'h0);
    rdchk("R9 zero ack no effect", A_RAW0, 32'h1);
    wr(A_ST0, 32'h1);
    rdchk("R9 ack clears line0", A_RAW0, 32'h0);
    rdchk("R9 line1 untouched", A_RAW1, 32'h1);
    tick();
    check("R10 irq drops", 32'(irq), 32'h0);
    wr(A_ST1, 32'h1);

    // R3 falling edge
    wr(A_FALL, 32'h2);
    pins[1] = 1'b1; tick();
    rdchk("R3 rise ignored on fall pin", A_RAW0, 32'h0);
    pins[1] = 1'b0; tick();
    rdchk("R3 fall recorded", A_RAW0, 32'h2);
    wr(A_ST0, 32'h2); wr(A_ST1, 32'h2);

    // R4 both edges
    wr(A_RISE, 32'h5); wr(A_FALL, 32'h6);
    pins[2] = 1'b1; tick();
    rdchk("R4 up edge", A_RAW0, 32'h4);
    wr(A_ST0, 32'h4);
    rdchk("R4 cleared", A_RAW0, 32'h0);
    pins[2] = 1'b0; tick();
    rdchk("R4 down edge", A_RAW0, 32'h4);
    wr(A_ST0, 32'h4); wr(A_ST1, 32'hFFFF_FFFF);

    // R5 high level persists through acknowledge
    wr(A_HIGH, 32'h8);
    pins[3] = 1'b1; tick();
    rdchk("R5 level set", A_RAW0, 32'h8);
    wr(A_ST0, 32'h8);
    rdchk("R5 ack while held", A_RAW0, 32'h8);
    pins[3] = 1'b0; tick();
    wr(A_ST0, 32'h8);
    rdchk("R5 ack after drop", A_RAW0, 32'h0);

    // R6 low level
    wr(A_LOW, 32'h10);
    tick();
    addr = A_RAW1; #1;
    check("R6 low level", rdata & 32'h10, 32'h10);
    wr(A_LOW, 32'h0);
    wr(A_ST0, 32'hFFFF_FFFF); wr(A_ST1, 32'hFFFF_FFFF);
    rdchk("R6 cleared", A_RAW0, 32'h0);

    // R11 event and ack collide
    wr(A_RISE, 32'h25);
    pins[5] = 1'b1; we = 1'b1; addr = A_ST0; wdata = 32'h20;
    tick(); we = 1'b0;
    rdchk("R11 event wins", A_RAW0, 32'h20);

    // R8 mask aliases
    wr(A_SET1, 32'hF0);
    wr(A_CLR1, 32'h30);
    rdchk("R8 set alias read", A_SET1, 32'hC0);
    rdchk("R8 clear alias read", A_CLR1, 32'hC0);
    wr(A_SET1, 32'h0); wr(A_CLR1, 32'h0);
    rdchk("R8 zero writes", A_SET1, 32'hC0);

    // R12 ignored writes
    wr(A_RAW0, 32'hFFFF_FFFF);
    rdchk("R12 raw write ignored", A_RAW0, 32'h20);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h21, 32'hFFFF_FFFF);
    rdchk("R12 unmapped read", 8'h30, 32'h0);
    rdchk("R12 misaligned write ignored", A_SET0, 32'h1);

    // Random phase, compared continuously with the model
    for (int i = 0; i < RAND_CYC; i++) begin
      int r;
      pins  = pins ^ ($urandom & $urandom & $urandom);
      we    = ($urandom % 3) == 0;
      r     = $urandom % 14;
      addr  = (r < 12) ? 8'(4*r) : ((r == 12) ? 8'h30 : 8'hF1);
      wdata = ($urandom % 2) ? ($urandom & $urandom) : $urandom;
      tick();
    end
    we = 1'b0;
    repeat (3) tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule